// File: doc/BRIEF.md
# Chained Watchpoint and Event Counter Unit

This unit sits behind the matchpoint comparators of a processor debug block. Each cycle that the comparators report a valid event, it folds the matchpoint hits into a linear chain of watchpoints. Every link can stand alone, require the link before it (AND), accept either itself or the link before it (OR), or be switched off. Two event counters sit inside the chain: matching watchpoints advance the counter they are assigned to, and a counter whose count has reached its programmed match value acts as the source of one of the two links that follow the matchpoint links. The final link takes an external hit line.

The result is registered: one cycle after an event, the unit presents the watchpoint vector and a single break request. The break request is the OR of the watchpoints whose break-enable bit is set. Configuration (chain modes, counter assignment, counter enables, break enables) is presented as static inputs. Each counter is a register with the count in the low half and the match value in the high half. It can be loaded through a write strobe and is readable at all times.

Top module: `wp_chain_unit`

## Requirements
- R1: After reset, the watchpoint vector, the break request and both counter registers (count and match) read zero.
- R2: Each watchpoint i has a 2-bit mode at chain_mode[2i+1:2i] with this encoding: 0 means the watchpoint follows its own source; 1 means its own source AND the previous watchpoint; 2 means its own source OR the previous watchpoint; 3 means it never matches.
- R3: Watchpoint 0 has no predecessor, so its second operand is matchpoint 0 itself. In modes 0, 1 and 2 it equals mp_hit[0]. Watchpoints 1 to NUM_MP-1 take mp_hit[i] as their own source.
- R4: Watchpoint NUM_MP uses "counter 0 count equals counter 0 match" as its own source. Watchpoint NUM_MP+1 uses the same equality for counter 1. Both comparisons use the counter value held before the current event.
- R5: The last watchpoint, NUM_MP+2, uses ext_hit as its own source.
- R6: ctr_sel[i] assigns watchpoint i to counter 1 when set and to counter 0 when clear. A counter whose ctr_en bit is set advances, in one event, by the number of matching watchpoints assigned to it. Each watchpoint adds at most one per cycle. A counter whose ctr_en bit is clear holds its count.
- R7: brk_q is set one cycle after an event exactly when some matching watchpoint has its brk_en bit set.
- R8: When evt_valid is low, or when every bit of both brk_en and ctr_sel is zero, no watchpoint matches, no break is requested and no counter advances.
- R9: The count is CNT_W bits wide (16 by default) and wraps from all ones to zero.
- R10: ctr_wr[k] loads counter k's register from ctr_wdata, with the count in the low CNT_W bits and the match value in the high CNT_W bits. A write takes priority over an increment in the same cycle.
- R11: wp_q, brk_q and the counter registers change only on the clock edge that follows the inputs they depend on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Matchpoint hits are valid this cycle |
| mp_hit | input | NUM_MP | Matchpoint hit vector |
| ext_hit | input | 1 | External source of the last watchpoint |
| chain_mode | input | 2*NUM_WP | Per-watchpoint chain mode, 2 bits each |
| ctr_sel | input | NUM_WP | Counter assignment per watchpoint (1 = counter 1) |
| ctr_en | input | 2 | Counter enables |
| brk_en | input | NUM_WP | Break-generate enable per watchpoint |
| ctr_wr | input | 2 | Counter register write strobes |
| ctr_wdata | input | 2*CNT_W | Counter register write value |
| ctr0_q | output | 2*CNT_W | Counter 0 register {match, count} |
| ctr1_q | output | 2*CNT_W | Counter 1 register {match, count} |
| wp_q | output | NUM_WP | Registered watchpoint vector |
| brk_q | output | 1 | Registered break request |

## Verification
The bench puts several watchpoints on one counter in a single event. A unit that adds one per cycle, instead of one per matching watchpoint, then falls behind. It runs counters into equality so the counter-sourced links fire. A unit that compares after the increment fires one event early. It drives a wrap from all ones, and a write in the same cycle as an increment, where an increment that wins loses the loaded value. It also clears every break and assignment bit while hits are present; a unit that ignores that gate still reports watchpoints and counts. Mode 3 and watchpoint 0 in AND/OR modes are driven directly, and a long run of random configurations is compared against a model built from the requirements.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      CH_OWN   = 2'd0,
      CH_AND   = 2'd1,
      CH_OR    = 2'd2,
      CH_NEVER = 2'd3
   } chain_mode_e;

   // combine a link's own source with its predecessor
   function automatic logic chain_apply(input logic [1:0] mode, input logic own, input logic prev);
      case (chain_mode_e'(mode))
         CH_OWN:  chain_apply = own;
         CH_AND:  chain_apply = own & prev;
         CH_OR:   chain_apply = own | prev;
         default: chain_apply = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/wpc_chain.sv
module wpc_chain
   import wpc_pkg::*;
#(
   parameter int NUM_MP = 8,
   localparam int NUM_WP = NUM_MP + 3
) (
   input  logic [NUM_MP-1:0]   mp_hit,
   input  logic [1:0]          ctr_eq,
   input  logic                ext_hit,
   input  logic [2*NUM_WP-1:0] mode_vec,
   input  logic                enable,
   output logic [NUM_WP-1:0]   wp_out
);

   logic [NUM_WP-1:0] own_src;

   // own source per link: matchpoints, then counter equalities, then external
   always_comb begin
      own_src = '0;
      own_src[NUM_MP-1:0] = mp_hit;
      own_src[NUM_MP]     = ctr_eq[0];
      own_src[NUM_MP+1]   = ctr_eq[1];
      own_src[NUM_MP+2]   = ext_hit;
   end

   // linear chain evaluated in one pass; link 0 chains with itself
   always_comb begin
      logic prev;
      logic link;
      wp_out = '0;
      prev   = own_src[0];
      for (int i = 0; i < NUM_WP; i++) begin
         link      = chain_apply(mode_vec[2*i +: 2], own_src[i], prev);
         wp_out[i] = enable & link;
         prev      = wp_out[i];
      end
   end

endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
   parameter int CNT_W  = 16,
   parameter int NUM_WP = 11,
   localparam int REG_W = 2 * CNT_W,
   localparam int INC_W = $clog2(NUM_WP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              cnt_en,
   input  logic [NUM_WP-1:0] hits,
   output logic [REG_W-1:0]  reg_q,
   output logic              eq
);

   logic [INC_W-1:0] inc;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] match_q;

   assign count_q = reg_q[CNT_W-1:0];
   assign match_q = reg_q[REG_W-1:CNT_W];
   assign eq      = (count_q == match_q);

   // one step per matching watchpoint in this event
   always_comb begin
      inc = '0;
      for (int i = 0; i < NUM_WP; i++) begin
         inc = inc + INC_W'(hits[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (wr_en) begin
         reg_q <= wr_data;
      end else if (cnt_en) begin
         reg_q[CNT_W-1:0] <= count_q + CNT_W'(inc);
      end
   end

   assert_hold_when_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (!cnt_en || inc == '0)) |=> $stable(reg_q));

   assert_wrap_to_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && cnt_en && inc == INC_W'(1) && count_q == {CNT_W{1'b1}}) |=> (reg_q[CNT_W-1:0] == '0));

   assert_write_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (reg_q == $past(wr_data)));

   assert_match_kept_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (reg_q[REG_W-1:CNT_W] == $past(match_q)));

endmodule

// File: rtl/wp_chain_unit.sv
module wp_chain_unit
   import wpc_pkg::*;
#(
   parameter int NUM_MP = 8,
   parameter int CNT_W  = 16,
   localparam int NUM_WP = NUM_MP + 3,
   localparam int REG_W  = 2 * CNT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [NUM_MP-1:0]   mp_hit,
   input  logic                ext_hit,
   input  logic [2*NUM_WP-1:0] chain_mode,
   input  logic [NUM_WP-1:0]   ctr_sel,
   input  logic [1:0]          ctr_en,
   input  logic [NUM_WP-1:0]   brk_en,
   input  logic [1:0]          ctr_wr,
   input  logic [REG_W-1:0]    ctr_wdata,
   output logic [REG_W-1:0]    ctr0_q,
   output logic [REG_W-1:0]    ctr1_q,
   output logic [NUM_WP-1:0]   wp_q,
   output logic                brk_q
);

   generate
      if (NUM_MP < 1 || NUM_MP > 64) begin : g_bad_mp
         $error("wp_chain_unit: NUM_MP must lie in 1..64");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cw
         $error("wp_chain_unit: CNT_W must lie in 2..32");
      end
   endgenerate

   logic              eval_en;
   logic [1:0]        ctr_eq;
   logic [NUM_WP-1:0] wp_c;
   logic              brk_c;
   logic [REG_W-1:0]  creg [2];

   // the chain is evaluated only if something consumes it
   assign eval_en = evt_valid & (|(brk_en | ctr_sel));

   wpc_chain #(.NUM_MP(NUM_MP)) u_chain (
      .mp_hit  (mp_hit),
      .ctr_eq  (ctr_eq),
      .ext_hit (ext_hit),
      .mode_vec(chain_mode),
      .enable  (eval_en),
      .wp_out  (wp_c)
   );

   generate
      for (genvar k = 0; k < 2; k++) begin : g_ctr
         logic [NUM_WP-1:0] assigned;
         assign assigned = (k == 0) ? (wp_c & ~ctr_sel) : (wp_c & ctr_sel);
         wpc_counter #(.CNT_W(CNT_W), .NUM_WP(NUM_WP)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctr_wr[k]),
            .wr_data(ctr_wdata),
            .cnt_en (ctr_en[k]),
            .hits   (assigned),
            .reg_q  (creg[k]),
            .eq     (ctr_eq[k])
         );
      end
   endgenerate

   assign ctr0_q = creg[0];
   assign ctr1_q = creg[1];
   assign brk_c  = |(wp_c & brk_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         brk_q <= 1'b0;
      end else begin
         wp_q  <= wp_c;
         brk_q <= brk_c;
      end
   end

   assert_brk_needs_wp_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_q |-> (|(wp_q)));

   assert_idle_no_wp_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid || (brk_en == '0 && ctr_sel == '0)) |=> (wp_q == '0 && !brk_q));

   assert_ext_source_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (chain_mode[2*NUM_WP-1 -: 2] == 2'd0) |=> (wp_q[NUM_WP-1] == ($past(ext_hit) && $past(eval_en))));

   generate
      for (genvar i = 0; i < NUM_WP; i++) begin : g_never
         assert_never_mode_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            (chain_mode[2*i +: 2] == 2'd3) |=> !wp_q[i]);
      end
   endgenerate

endmodule

// File: tb/wp_chain_unit_tb.sv
`timescale 1ns/1ps
module wp_chain_unit_tb;

   localparam int NMP = 8;
   localparam int NWP = NMP + 3;
   localparam int CW  = 16;

   typedef struct {
      logic [NWP-1:0]  wp;
      logic            brk;
      logic [2*CW-1:0] c0;
      logic [2*CW-1:0] c1;
      string           tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt_valid = 1'b0;
   logic [NMP-1:0]    mp_hit = '0;
   logic              ext_hit = 1'b0;
   logic [2*NWP-1:0]  chain_mode = '0;
   logic [NWP-1:0]    ctr_sel = '0;
   logic [1:0]        ctr_en = '0;
   logic [NWP-1:0]    brk_en = '0;
   logic [1:0]        ctr_wr = '0;
   logic [2*CW-1:0]   ctr_wdata = '0;
   logic [2*CW-1:0]   ctr0_q, ctr1_q;
   logic [NWP-1:0]    wp_q;
   logic              brk_q;

   int n_chk = 0;
   int n_bad = 0;
   exp_t sb_q[$];
   logic [2*CW-1:0] m_reg [2];

   always #2.5 clk = ~clk;

   wp_chain_unit #(.NUM_MP(NMP), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .mp_hit(mp_hit),
      .ext_hit(ext_hit), .chain_mode(chain_mode), .ctr_sel(ctr_sel),
      .ctr_en(ctr_en), .brk_en(brk_en), .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
      .ctr0_q(ctr0_q), .ctr1_q(ctr1_q), .wp_q(wp_q), .brk_q(brk_q)
   );

   function automatic logic [2*NWP-1:0] all_modes(input logic [1:0] m);
      logic [2*NWP-1:0] v;
      for (int i = 0; i < NWP; i++) v[2*i +: 2] = m;
      return v;
   endfunction

   // expected result of the current inputs, built from the requirements
   task automatic predict(output exp_t e, input string tag);
      logic gate, own, prev, r;
      logic [NWP-1:0] w;
      int add0, add1;
      gate = evt_valid && ((brk_en | ctr_sel) != '0);
      prev = mp_hit[0];
      for (int i = 0; i < NWP; i++) begin
         if (i < NMP)        own = mp_hit[i];
         else if (i == NMP)  own = (m_reg[0][CW-1:0] == m_reg[0][2*CW-1:CW]);
         else if (i == NMP+1) own = (m_reg[1][CW-1:0] == m_reg[1][2*CW-1:CW]);
         else                own = ext_hit;
         case (chain_mode[2*i +: 2])
            2'd0: r = own;
            2'd1: r = own && prev;
            2'd2: r = own || prev;
            default: r = 1'b0;
         endcase
         w[i] = gate && r;
         prev = w[i];
      end
      add0 = 0; add1 = 0;
      for (int i = 0; i < NWP; i++) begin
         if (w[i] && !ctr_sel[i]) add0++;
         if (w[i] &&  ctr_sel[i]) add1++;
      end
      if (ctr_wr[0]) m_reg[0] = ctr_wdata;
      else if (ctr_en[0]) m_reg[0][CW-1:0] = m_reg[0][CW-1:0] + CW'(add0);
      if (ctr_wr[1]) m_reg[1] = ctr_wdata;
      else if (ctr_en[1]) m_reg[1][CW-1:0] = m_reg[1][CW-1:0] + CW'(add1);
      e.wp = w; e.brk = |(w & brk_en); e.c0 = m_reg[0]; e.c1 = m_reg[1]; e.tag = tag;
   endtask

   // driver: inputs already set by caller; push expectation after the edge
   task automatic step(input string tag);
      exp_t e;
      predict(e, tag);
      @(posedge clk);
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   // monitor: compare one expectation per falling edge
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (wp_q !== e.wp || brk_q !== e.brk || ctr0_q !== e.c0 || ctr1_q !== e.c1) begin
            n_bad++;
            $display("FAIL %s: got wp=%h brk=%b c0=%h c1=%h, expected wp=%h brk=%b c0=%h c1=%h",
                     e.tag, wp_q, brk_q, ctr0_q, ctr1_q, e.wp, e.brk, e.c0, e.c1);
         end
      end
   end

   task automatic idle_inputs();
      evt_valid = 1'b0; ctr_wr = '0; ext_hit = 1'b0; mp_hit = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_reg[0] = '0; m_reg[1] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (wp_q !== '0 || brk_q !== 1'b0 || ctr0_q !== '0 || ctr1_q !== '0) begin
         n_bad++;
         $display("FAIL R1: got wp=%h brk=%b c0=%h c1=%h, expected all zero", wp_q, brk_q, ctr0_q, ctr1_q);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2 mode 0, own sources (counters at 0==0 so links 8/9 fire: R4)
      brk_en = '1; evt_valid = 1'b1; mp_hit = 8'hA5; chain_mode = all_modes(2'd0);
      step("R2 own mode");
      mp_hit = 8'b1011_0111; chain_mode = all_modes(2'd1);
      step("R2 AND chain");
      mp_hit = 8'b0000_0100; chain_mode = all_modes(2'd2);
      step("R2 OR chain");
      mp_hit = '1; ext_hit = 1'b1; chain_mode = all_modes(2'd3);
      step("R2 never mode");
      // R3: link 0 in AND/OR equals mp_hit[0]
      ext_hit = 1'b0; mp_hit = 8'h01; chain_mode = all_modes(2'd1);
      step("R3 link0 AND");
      mp_hit = 8'h00; chain_mode = all_modes(2'd2);
      step("R3 link0 OR clear");
      // R5: external link alone
      chain_mode = all_modes(2'd3); chain_mode[2*(NWP-1) +: 2] = 2'd0; ext_hit = 1'b1;
      step("R5 ext hit");
      ext_hit = 1'b0;
      step("R5 ext low");

      // R10: load counter 0 with match 3, count 0
      idle_inputs(); ctr_wr = 2'b01; ctr_wdata = {16'd3, 16'd0};
      step("R10 load c0");
      // R4/R6: link 0 counts into counter 0, link 8 own
      ctr_wr = '0; ctr_en = 2'b11; ctr_sel = '0; brk_en = 11'b001_0000_0000;
      chain_mode = all_modes(2'd3); chain_mode[1:0] = 2'd0; chain_mode[2*NMP +: 2] = 2'd0;
      evt_valid = 1'b1; mp_hit = 8'h01;
      for (int k = 0; k < 5; k++) step("R4 count to match");
      // R6: several links on counter 1 in one event
      ctr_sel = 11'b000_0000_1111; chain_mode = all_modes(2'd0); mp_hit = 8'h0F; brk_en = '0;
      step("R6 multi inc c1");
      step("R6 multi inc c1 again");
      // R6: counter disabled holds
      ctr_en = 2'b01;
      step("R6 c1 disabled");
      // R8: no event, then gate closed
      evt_valid = 1'b0; ctr_en = 2'b11;
      step("R8 no event");
      evt_valid = 1'b1; ctr_sel = '0; brk_en = '0; mp_hit = '1;
      step("R8 gate closed");
      // R9: wrap
      idle_inputs(); ctr_wr = 2'b10; ctr_wdata = {16'h1234, 16'hFFFF};
      step("R9 preload");
      ctr_wr = '0; evt_valid = 1'b1; ctr_sel = 11'h001; chain_mode = all_modes(2'd3);
      chain_mode[1:0] = 2'd0; mp_hit = 8'h01;
      step("R9 wrap");
      // R10: write beats increment
      ctr_wr = 2'b10; ctr_wdata = {16'h0002, 16'h0040};
      step("R10 write over inc");
      // R11 plus all rules: random configurations
      for (int n = 0; n < 300; n++) begin
         evt_valid  = ($urandom % 4) != 0;
         mp_hit     = NMP'($urandom);
         ext_hit    = $urandom % 2;
         chain_mode = (2*NWP)'($urandom);
         ctr_sel    = NWP'($urandom);
         ctr_en     = 2'($urandom);
         brk_en     = (($urandom % 5) == 0) ? '0 : NWP'($urandom);
         ctr_wr     = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         ctr_wdata  = {16'($urandom % 6), 16'($urandom % 6)};
         step("R11 random");
      end
      idle_inputs();
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule